// File: doc/BRIEF.md
# Synaptic Delay Ring Accumulator

This block schedules synaptic input for a set of spiking neurons. Each arriving 32-bit synapse word carries a target neuron, a signed weight and a 4-bit delay. The weight is added into one of sixteen time slots that belong to that neuron. The slot is the current time slot offset by the delay, so an input can land up to fifteen ticks in the future.

A shared time pointer moves forward by one slot on each 1 ms tick and wraps around the ring. The neuron update logic reads a neuron's slot for the present tick through the read port. The read returns the accumulated total and empties the slot, so the slot is ready when the pointer comes back to it sixteen ticks later.

Top module: `syn_delay_ring`

## Requirements
- R1: A synapse word is decoded as follows: bits [31:28] are the delay, bit [27] is ignored, bits [26:16] are the target neuron index, and bits [15:0] are the weight.
- R2: Each neuron owns 16 slots. A 4-bit time pointer resets to 0, advances by one in every cycle where `tick_i` is high, and wraps from 15 to 0.
- R3: An accepted word adds its weight into slot (pointer + delay) mod 16 of its neuron. After exactly `delay` ticks, a read of that neuron returns the sum.
- R4: The weight is signed two's complement, so a negative weight lowers the slot total.
- R5: A slot total saturates at the signed limits of an `ACC_W`-bit value instead of wrapping around.
- R6: When `rd_req_i` is high, `rd_valid_o` is high in the next cycle, and `rd_total_o` holds the selected neuron's current slot. That slot becomes zero. No other slot changes.
- R7: `syn_ready_o` is low in any cycle where `rd_req_i` is high. A pending word then waits and is accepted after the read.
- R8: A word whose index is at or above `N_NEURON` changes no slot. It increments `err_count_o`, which saturates at all ones.
- R9: When a tick arrives in the same cycle as a word or a read, that word or read uses the pointer value from before the tick.
- R10: After reset all slots are zero, `rd_valid_o` is low and `err_count_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time step pulse; advances the slot pointer |
| syn_valid_i | input | 1 | Synapse word valid |
| syn_word_i | input | 32 | Synapse word (delay, spare bit, index, weight) |
| syn_ready_o | output | 1 | Synapse word can be accepted |
| rd_req_i | input | 1 | Read-and-clear request for one neuron |
| rd_idx_i | input | RD_IDX_W | Neuron to read, below `N_NEURON` |
| rd_valid_o | output | 1 | Read result valid, one cycle after the request |
| rd_total_o | output | ACC_W | Current-slot total of the neuron that was read |
| err_count_o | output | ERR_W | Count of out-of-range words, saturating |

## Verification
The bench builds the block with `N_NEURON=6`, so the index field can name neurons that do not exist. With six neurons, an index of 8 would alias to neuron 0 if the range test were dropped. It also uses `ACC_W=20`, which lets about twenty full-scale weights push a slot to either saturation limit. `ERR_W=3` lets nine bad words drive the error counter past its ceiling. The pointer is driven around the ring so that a delay reaches past slot 15 and wraps.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  localparam int unsigned SLOT_N = 16;
  localparam int unsigned SLOT_W = 4;
  localparam int unsigned WT_W   = 16;
  localparam int unsigned IDX_FW = 11;
  localparam int unsigned WORD_W = 32;

  typedef struct packed {
    logic [SLOT_W-1:0] dly;
    logic              spare;
    logic [IDX_FW-1:0] idx;
    logic [WT_W-1:0]   wt;
  } syn_word_t;
endpackage

// File: rtl/sdr_sat_add.sv
module sdr_sat_add #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned WT_W  = 16
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [WT_W-1:0]  wt_i,
  output logic [ACC_W-1:0] sum_o
);
  localparam int unsigned EXT_W = ACC_W + 1;
  localparam logic [ACC_W-1:0] MAX_V = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_V = {1'b1, {(ACC_W-1){1'b0}}};

  logic [EXT_W-1:0] acc_x, wt_x, wide;

  assign acc_x = {acc_i[ACC_W-1], acc_i};
  assign wt_x  = {{(EXT_W-WT_W){wt_i[WT_W-1]}}, wt_i};
  assign wide  = acc_x + wt_x;

  // top two bits disagree -> result left the ACC_W range
  always_comb begin
    if (wide[EXT_W-1] != wide[EXT_W-2]) sum_o = wide[EXT_W-1] ? MIN_V : MAX_V;
    else                                sum_o = wide[ACC_W-1:0];
  end
endmodule

// File: rtl/sdr_slot_bank.sv
module sdr_slot_bank #(
  parameter int unsigned ACC_W = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [sdr_pkg::SLOT_W-1:0] wr_slot_i,
  input  logic [sdr_pkg::WT_W-1:0]   wt_i,
  input  logic                      clr_en_i,
  input  logic [sdr_pkg::SLOT_W-1:0] clr_slot_i,
  output logic [ACC_W-1:0]          rd_data_o
);
  import sdr_pkg::*;

  logic [ACC_W-1:0] slots_q [SLOT_N];
  logic [ACC_W-1:0] sum;

  sdr_sat_add #(.ACC_W(ACC_W), .WT_W(WT_W)) u_add (
    .acc_i (slots_q[wr_slot_i]),
    .wt_i  (wt_i),
    .sum_o (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SLOT_N; s++) slots_q[s] <= '0;
    end else begin
      if (wr_en_i)  slots_q[wr_slot_i]  <= sum;
      if (clr_en_i) slots_q[clr_slot_i] <= '0;
    end
  end

  assign rd_data_o = slots_q[clr_slot_i];

  AST_NO_RW_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && clr_en_i)); // R7

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> slots_q[$past(clr_slot_i)] == '0); // R6

  AST_SAT_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && slots_q[wr_slot_i][ACC_W-1] == wt_i[WT_W-1])
    |=> slots_q[$past(wr_slot_i)][ACC_W-1] == $past(wt_i[WT_W-1])); // R5
endmodule

// File: rtl/syn_delay_ring.sv
module syn_delay_ring #(
  parameter int unsigned N_NEURON = 8,
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned ERR_W    = 8,
  localparam int unsigned RD_IDX_W = (N_NEURON > 1) ? $clog2(N_NEURON) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                syn_valid_i,
  input  logic [31:0]         syn_word_i,
  output logic                syn_ready_o,
  input  logic                rd_req_i,
  input  logic [RD_IDX_W-1:0] rd_idx_i,
  output logic                rd_valid_o,
  output logic [ACC_W-1:0]    rd_total_o,
  output logic [ERR_W-1:0]    err_count_o
);
  import sdr_pkg::*;

  localparam logic [IDX_FW-1:0] IDX_LIM = IDX_FW'(N_NEURON);

  syn_word_t          w;
  logic               spare_unused;
  logic               accept, idx_ok;
  logic [SLOT_W-1:0]  ptr_q, tgt_slot;
  logic [ERR_W-1:0]   err_q;
  logic               rd_valid_q;
  logic [ACC_W-1:0]   rd_total_q, rd_mux;
  logic [ACC_W-1:0]   bank_rd [N_NEURON];

  assign w            = syn_word_i;
  assign spare_unused = w.spare;
  assign syn_ready_o  = !rd_req_i;  // read owns the cycle
  assign accept       = syn_valid_i && syn_ready_o;
  assign idx_ok       = w.idx < IDX_LIM;
  assign tgt_slot     = ptr_q + w.dly;  // 4-bit wrap

  for (genvar n = 0; n < N_NEURON; n++) begin : g_bank
    logic wr_en, clr_en;
    assign wr_en  = accept && idx_ok && (w.idx == IDX_FW'(n));
    assign clr_en = rd_req_i && (rd_idx_i == RD_IDX_W'(n));
    sdr_slot_bank #(.ACC_W(ACC_W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en),
      .wr_slot_i  (tgt_slot),
      .wt_i       (w.wt),
      .clr_en_i   (clr_en),
      .clr_slot_i (ptr_q),
      .rd_data_o  (bank_rd[n])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int n = 0; n < N_NEURON; n++)
      if (rd_idx_i == RD_IDX_W'(n)) rd_mux = bank_rd[n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      err_q      <= '0;
      rd_valid_q <= 1'b0;
      rd_total_q <= '0;
    end else begin
      if (tick_i) ptr_q <= ptr_q + 1'b1;
      if (accept && !idx_ok && err_q != '1) err_q <= err_q + 1'b1;
      rd_valid_q <= rd_req_i;
      if (rd_req_i) rd_total_q <= rd_mux;
    end
  end

  assign rd_valid_o  = rd_valid_q;
  assign rd_total_o  = rd_total_q;
  assign err_count_o = err_q;

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(ptr_q)); // R2

  AST_RD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_valid_o); // R6

  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && idx_ok) |=> $stable(err_count_o)); // R8

  AST_ERR_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_count_o == '1) |=> (err_count_o == '1)); // R8
endmodule

// File: tb/syn_delay_ring_tb.sv
`timescale 1ns/1ps
module syn_delay_ring_tb;
  localparam int NN  = 6;
  localparam int AW  = 20;
  localparam int EW  = 3;
  localparam int RIW = 3;
  localparam longint MAXV = (longint'(1) << (AW-1)) - 1;
  localparam longint MINV = -(longint'(1) << (AW-1));

  logic clk = 0, rst_n = 0;
  logic tick = 0, syn_valid = 0, rd_req = 0;
  logic [31:0] syn_word = '0;
  logic [RIW-1:0] rd_idx = '0;
  logic syn_ready, rd_valid;
  logic [AW-1:0] rd_total;
  logic [EW-1:0] err_count;

  always #2.5 clk = ~clk;

  syn_delay_ring #(.N_NEURON(NN), .ACC_W(AW), .ERR_W(EW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .syn_valid_i(syn_valid), .syn_word_i(syn_word), .syn_ready_o(syn_ready),
    .rd_req_i(rd_req), .rd_idx_i(rd_idx),
    .rd_valid_o(rd_valid), .rd_total_o(rd_total), .err_count_o(err_count)
  );

  int total = 0, bad = 0;
  longint model [NN][16];
  int mptr = 0;
  longint exp_q[$];
  string  req_q[$];

  function automatic longint sat(longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model side of an accepted word
  task automatic model_word(int dly, int idx, int wt);
    if (idx < NN) model[idx][(mptr + dly) % 16] = sat(model[idx][(mptr + dly) % 16] + wt);
  endtask

  task automatic model_read(int idx, string req);
    exp_q.push_back(model[idx][mptr]);
    req_q.push_back(req);
    model[idx][mptr] = 0;
  endtask

  // all driver tasks start and end just after a falling edge
  task automatic send(int dly, int idx, int wt, bit tk = 0, bit spare = 0);
    syn_word  = {dly[3:0], spare, idx[10:0], wt[15:0]};
    syn_valid = 1;
    tick      = tk;
    model_word(dly, idx, wt);
    if (tk) mptr = (mptr + 1) % 16;
    @(negedge clk);
    syn_valid = 0;
    tick      = 0;
  endtask

  task automatic do_tick(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1;
      mptr = (mptr + 1) % 16;
      @(negedge clk);
      tick = 0;
    end
  endtask

  task automatic do_read(int idx, string req, bit tk = 0);
    rd_req = 1;
    rd_idx = idx[RIW-1:0];
    tick   = tk;
    model_read(idx, req);
    if (tk) mptr = (mptr + 1) % 16;
    @(negedge clk);
    rd_req = 0;
    tick   = 0;
  endtask

  // read and word in the same cycle: word must wait (R7)
  task automatic read_and_word(int idx, int dly, int widx, int wt);
    rd_req    = 1;
    rd_idx    = idx[RIW-1:0];
    syn_word  = {dly[3:0], 1'b0, widx[10:0], wt[15:0]};
    syn_valid = 1;
    model_read(idx, "R7");
    #1;
    chk(syn_ready == 1'b0, "R7 ready during read", syn_ready, 0);
    @(negedge clk);
    rd_req = 0;
    #1;
    chk(syn_ready == 1'b1, "R7 ready after read", syn_ready, 1);
    model_word(dly, widx, wt);
    @(negedge clk);
    syn_valid = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R6 unexpected rd_valid", 1, 0);
      end else begin
        automatic longint e = exp_q.pop_front();
        automatic string  r = req_q.pop_front();
        automatic longint a = longint'($signed(rd_total));
        chk(a == e, r, a, e);
      end
    end
  end

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < NN; n++) for (int s = 0; s < 16; s++) model[n][s] = 0;
    repeat (3) @(negedge clk);
    chk(rd_valid == 0, "R10 rd_valid", rd_valid, 0);
    chk(err_count == 0, "R10 err_count", err_count, 0);
    rst_n = 1;
    @(negedge clk);
    chk(syn_ready == 1, "R10 ready", syn_ready, 1);
    do_read(2, "R10 slot zero");

    // R3: zero delay, then clear on read (R6)
    send(0, 0, 100);
    do_read(0, "R3 delay 0");
    do_read(0, "R6 cleared");

    // R3/R4: delay 3, mixed signs, early read sees nothing
    send(3, 1, -40);
    send(3, 1, 50);
    do_tick(2);
    do_read(1, "R3 early read");
    do_tick(1);
    do_read(1, "R4 signed sum");

    // R1: spare bit ignored
    send(1, 2, 7, 0, 1);
    do_tick(1);
    do_read(2, "R1 spare bit");

    // R9: tick with word uses pre-tick pointer
    send(1, 3, 9, 1);
    do_read(3, "R9 tick with word");

    // R2: wrap of target slot past 15
    do_tick((14 - mptr + 16) % 16);
    send(5, 4, 300);
    do_tick(4);
    do_read(4, "R2 before wrap target");
    do_tick(1);
    do_read(4, "R2 wrapped slot");

    // R5: saturation both ways
    for (int i = 0; i < 20; i++) send(2, 5, 32767);
    do_tick(2);
    do_read(5, "R5 positive limit");
    for (int i = 0; i < 20; i++) send(0, 5, -32768);
    do_read(5, "R5 negative limit");

    // R7: stall then accept
    send(0, 0, 4);
    read_and_word(0, 0, 0, 11);
    do_read(0, "R7 delayed word");

    // R8: bad indices, no aliasing into neuron 0
    send(0, 8, 77);
    send(0, 6, 5);
    chk(err_count == 2, "R8 err count", err_count, 2);
    do_read(0, "R8 no alias");
    for (int i = 0; i < 7; i++) send(0, 2047, 1);
    chk(err_count == 3'b111, "R8 err saturates", err_count, 7);

    // R9: read with tick uses pre-tick slot
    send(1, 1, 13);
    do_read(1, "R9 read with tick", 1);
    do_read(1, "R9 next slot");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6 reads answered", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule